// File: doc/BRIEF.md
# Trimmed-Mean Sample Filter

This block reduces a stream of raw readings from one sensing point to a single filtered value. It gathers a set of successive samples, optionally discards the highest and lowest values of the set, and averages what is left with a right shift. The set size, and whether trimming applies, come from a 3-bit mode code. A control word holds one mode code for each sensing point, and the point index chooses which code applies.

The filter keeps a running sum, a running maximum and a running minimum while a set is in progress. When the last sample of the set arrives, it subtracts the extremes if the mode calls for it and shifts the result right by log2 of the number of samples that remain. The mode and point are captured with the first sample of a set, so the upstream scheduler may change them while the set is in flight. A new set can start on the very next cycle. Deciding when to sample and converting the result to a temperature are the job of neighbouring logic.

Top module: `trim_mean_filter`

## Requirements
- R1: Mode code 3'b000 uses a single sample, and out_data equals that sample.
- R2: Mode code 3'b001 uses two samples, and out_data is their sum shifted right by 1.
- R3: Mode code 3'b010 uses four samples, drops one largest and one smallest, and outputs the sum of the other two shifted right by 1.
- R4: Mode code 3'b011 uses six samples, drops one largest and one smallest, and outputs the sum of the middle four shifted right by 2.
- R5: Mode code 3'b100 uses ten samples, drops one largest and one smallest, and outputs the sum of the middle eight shifted right by 3.
- R6: Mode code 3'b101 uses eighteen samples, drops one largest and one smallest, and outputs the sum of the middle sixteen shifted right by 4.
- R7: The mode for point p is ctrl_word[3p+2:3p]. With the default of four points, point 0 uses bits [2:0] and point 3 uses bits [11:9].
- R8: Mode codes 3'b110 and 3'b111 behave like 3'b000.
- R9: out_valid is high for exactly the one cycle after the clock edge that captures the last sample of a set, and at no other time.
- R10: A new set may begin with the sample in the cycle right after the last sample of the previous set, with no idle cycle in between.
- R11: Mode and point are taken from the first sample of a set. Changes to ctrl_word or pt_sel during the rest of the set have no effect on that set.
- R12: Asserting reset clears out_valid and out_data to 0 and discards any partly collected set.
- R13: Cycles with smp_valid low add nothing to a set.
- R14: out_data holds its value between done pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_data | input | SMP_W | Unsigned raw sample |
| pt_sel | input | PT_W | Sensing point index, used with the first sample of a set |
| ctrl_word | input | 3*NUM_PTS | One 3-bit mode code per point |
| out_valid | output | 1 | One-cycle done pulse |
| out_data | output | SMP_W | Filtered value of the last completed set |

## Verification
Each result is due one clock after the edge that captures the final sample of its set. The output register is the only stage between the accumulator and the ports. The bench changes inputs at the falling edge and reads the outputs at the next falling edge. The done pulse and value are therefore checked exactly one cycle after the last sample was driven, and out_valid is confirmed low after every earlier sample of the set. Back-to-back sets are driven with no gap, so the pulse of one set and the first sample of the next meet in the same cycle. Idle, reset and hold checks read the ports in each cycle of the window they cover.

// File: rtl/tfilt_pkg.sv
package tfilt_pkg;

  localparam int MODE_W = 3;
  localparam int CNT_W  = 5;
  localparam int SH_W   = 3;

  typedef enum logic [MODE_W-1:0] {
    FM_ONE   = 3'd0,
    FM_PAIR  = 3'd1,
    FM_MID2  = 3'd2,
    FM_MID4  = 3'd3,
    FM_MID8  = 3'd4,
    FM_MID16 = 3'd5,
    FM_RSV6  = 3'd6,
    FM_RSV7  = 3'd7
  } fmode_e;

  // How one set is gathered and reduced.
  typedef struct packed {
    logic [CNT_W-1:0] need;   // samples in the set
    logic             trim;   // discard max and min
    logic [SH_W-1:0]  shamt;  // log2 of the samples kept
  } plan_t;

  function automatic plan_t plan_of(input logic [MODE_W-1:0] code);
    plan_t p;
    case (fmode_e'(code))
      FM_PAIR:  p = '{need: 5'd2,  trim: 1'b0, shamt: 3'd1};
      FM_MID2:  p = '{need: 5'd4,  trim: 1'b1, shamt: 3'd1};
      FM_MID4:  p = '{need: 5'd6,  trim: 1'b1, shamt: 3'd2};
      FM_MID8:  p = '{need: 5'd10, trim: 1'b1, shamt: 3'd3};
      FM_MID16: p = '{need: 5'd18, trim: 1'b1, shamt: 3'd4};
      default:  p = '{need: 5'd1,  trim: 1'b0, shamt: 3'd0};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/tfilt_mode_sel.sv
module tfilt_mode_sel
  import tfilt_pkg::*;
#(
  parameter int NUM_PTS = 4,
  localparam int PT_W   = (NUM_PTS > 1) ? $clog2(NUM_PTS) : 1,
  localparam int CTRL_W = NUM_PTS * MODE_W
) (
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic [PT_W-1:0]   pt_sel,
  output plan_t             plan
);

  logic [MODE_W-1:0] field [NUM_PTS];

  for (genvar p = 0; p < NUM_PTS; p++) begin : g_field
    assign field[p] = ctrl_word[p*MODE_W +: MODE_W];
  end

  assign plan = plan_of(field[pt_sel]);

endmodule

// File: rtl/tfilt_accum.sv
module tfilt_accum
  import tfilt_pkg::*;
#(
  parameter int SMP_W = 16,
  parameter int SUM_W = SMP_W + 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_data,
  input  plan_t            plan_new,
  output logic             busy,
  output logic             fin,
  output logic [SUM_W-1:0] fin_sum,
  output logic [SMP_W-1:0] fin_hi,
  output logic [SMP_W-1:0] fin_lo,
  output logic             fin_trim,
  output logic [SH_W-1:0]  fin_shamt
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  plan_t            held_q, held_d;
  logic [SUM_W-1:0] sum_q, sum_d;
  logic [SMP_W-1:0] hi_q, hi_d, lo_q, lo_d;
  logic             first, last;
  logic [CNT_W-1:0] cnt_inc;
  logic [SUM_W-1:0] smp_ext;

  always_comb begin
    first   = (cnt_q == '0);
    held_d  = first ? plan_new : held_q;
    cnt_inc = cnt_q + 1'b1;
    smp_ext = {{(SUM_W-SMP_W){1'b0}}, smp_data};
    sum_d   = first ? smp_ext : sum_q + smp_ext;
    hi_d    = (first || smp_data > hi_q) ? smp_data : hi_q;
    lo_d    = (first || smp_data < lo_q) ? smp_data : lo_q;
    last    = smp_valid && (cnt_inc == held_d.need);
    cnt_d   = last ? '0 : cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      held_q <= '0;
      sum_q  <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else if (smp_valid) begin
      cnt_q  <= cnt_d;
      held_q <= held_d;
      sum_q  <= sum_d;
      hi_q   <= hi_d;
      lo_q   <= lo_d;
    end
  end

  assign busy      = (cnt_q != '0);
  assign fin       = last;
  assign fin_sum   = sum_d;
  assign fin_hi    = hi_d;
  assign fin_lo    = lo_d;
  assign fin_trim  = held_d.trim;
  assign fin_shamt = held_d.shamt;

endmodule

// File: rtl/tfilt_result.sv
module tfilt_result
  import tfilt_pkg::*;
#(
  parameter int SMP_W = 16,
  parameter int SUM_W = SMP_W + 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fin,
  input  logic [SUM_W-1:0] fin_sum,
  input  logic [SMP_W-1:0] fin_hi,
  input  logic [SMP_W-1:0] fin_lo,
  input  logic             fin_trim,
  input  logic [SH_W-1:0]  fin_shamt,
  output logic             out_valid,
  output logic [SMP_W-1:0] out_data
);

  logic [SUM_W-1:0] extremes, kept;
  logic [SMP_W-1:0] data_d;

  always_comb begin
    extremes = fin_trim ? ({{(SUM_W-SMP_W){1'b0}}, fin_hi} +
                           {{(SUM_W-SMP_W){1'b0}}, fin_lo}) : '0;
    kept     = fin_sum - extremes;
    data_d   = fin ? SMP_W'(kept >> fin_shamt) : out_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= fin;
      out_data  <= data_d;
    end
  end

endmodule

// File: rtl/trim_mean_filter.sv
module trim_mean_filter
  import tfilt_pkg::*;
#(
  parameter int SMP_W   = 16,
  parameter int NUM_PTS = 4,
  localparam int PT_W   = (NUM_PTS > 1) ? $clog2(NUM_PTS) : 1,
  localparam int CTRL_W = NUM_PTS * MODE_W,
  localparam int SUM_W  = SMP_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp_data,
  input  logic [PT_W-1:0]   pt_sel,
  input  logic [CTRL_W-1:0] ctrl_word,
  output logic              out_valid,
  output logic [SMP_W-1:0]  out_data
);

  plan_t            plan_new;
  logic             busy, fin, fin_trim;
  logic [SUM_W-1:0] fin_sum;
  logic [SMP_W-1:0] fin_hi, fin_lo;
  logic [SH_W-1:0]  fin_shamt;

  tfilt_mode_sel #(.NUM_PTS(NUM_PTS)) u_sel (
    .ctrl_word (ctrl_word),
    .pt_sel    (pt_sel),
    .plan      (plan_new)
  );

  tfilt_accum #(.SMP_W(SMP_W), .SUM_W(SUM_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .plan_new  (plan_new),
    .busy      (busy),
    .fin       (fin),
    .fin_sum   (fin_sum),
    .fin_hi    (fin_hi),
    .fin_lo    (fin_lo),
    .fin_trim  (fin_trim),
    .fin_shamt (fin_shamt)
  );

  tfilt_result #(.SMP_W(SMP_W), .SUM_W(SUM_W)) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .fin       (fin),
    .fin_sum   (fin_sum),
    .fin_hi    (fin_hi),
    .fin_lo    (fin_lo),
    .fin_trim  (fin_trim),
    .fin_shamt (fin_shamt),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

endmodule

// File: rtl/tfilt_chk.sv
module tfilt_chk #(
  parameter int SMP_W   = 16,
  parameter int NUM_PTS = 4,
  localparam int PT_W   = (NUM_PTS > 1) ? $clog2(NUM_PTS) : 1,
  localparam int CTRL_W = NUM_PTS * 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic [SMP_W-1:0]  smp_data,
  input logic [PT_W-1:0]   pt_sel,
  input logic [CTRL_W-1:0] ctrl_word,
  input logic              busy,
  input logic              out_valid,
  input logic [SMP_W-1:0]  out_data
);

  logic [2:0] code_now;
  assign code_now = 3'(ctrl_word >> (pt_sel * 3));

  // R1
  single_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && !busy && (code_now == 3'd0) |=> out_valid && (out_data == $past(smp_data)));

  // R8
  reserved_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && !busy && (code_now[2:1] == 2'b11) |=> out_valid && (out_data == $past(smp_data)));

  // R2
  pair_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && !busy && (code_now == 3'd1) |=> busy && !out_valid);

  // R9
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(smp_valid));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !busy);

  // R14
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

endmodule

bind trim_mean_filter tfilt_chk #(.SMP_W(SMP_W), .NUM_PTS(NUM_PTS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_valid (smp_valid),
  .smp_data  (smp_data),
  .pt_sel    (pt_sel),
  .ctrl_word (ctrl_word),
  .busy      (busy),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/trim_mean_filter_test.sv
`timescale 1ns/1ps
module trim_mean_filter_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_valid;
  logic [15:0] smp_data;
  logic [1:0]  pt_sel;
  logic [11:0] ctrl_word;
  logic        out_valid;
  logic [15:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] sbuf [18];

  always #2.5 clk = ~clk;

  trim_mean_filter uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .pt_sel    (pt_sel),
    .ctrl_word (ctrl_word),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  // {point, mode, base, step}
  localparam logic [36:0] VTAB [10] = '{
    {2'd0, 3'd0, 16'h1234, 16'd5},
    {2'd1, 3'd1, 16'h0100, 16'd7},
    {2'd2, 3'd2, 16'h8000, 16'd9},
    {2'd3, 3'd3, 16'h0040, 16'd17},
    {2'd0, 3'd4, 16'h2000, 16'd23},
    {2'd1, 3'd5, 16'hF000, 16'd29},
    {2'd2, 3'd6, 16'h0777, 16'd3},
    {2'd3, 3'd7, 16'hABCD, 16'd1},
    {2'd3, 3'd5, 16'h0000, 16'd31},
    {2'd1, 3'd3, 16'h5555, 16'd0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int need_of(input logic [2:0] m);
    case (m)
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 6;
      3'd4: return 10;
      3'd5: return 18;
      default: return 1;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] m);
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R8";
    endcase
  endfunction

  // Sort the set and average the middle part (R3..R6 drop one each end).
  function automatic logic [15:0] expect_of(input logic [2:0] m);
    int n = need_of(m);
    int drop = (m >= 3'd2 && m <= 3'd5) ? 1 : 0;
    int v [18];
    int acc = 0;
    for (int i = 0; i < n; i++) v[i] = int'(sbuf[i]);
    for (int i = 0; i < n; i++)
      for (int j = 0; j < n - 1 - i; j++)
        if (v[j] > v[j+1]) begin
          int t = v[j];
          v[j] = v[j+1];
          v[j+1] = t;
        end
    for (int i = drop; i < n - drop; i++) acc += v[i];
    return 16'(acc / (n - 2*drop));
  endfunction

  // Other fields hold 3'b101 so a wrong field would change the set size (R7).
  function automatic logic [11:0] ctrl_for(input logic [1:0] p, input logic [2:0] m);
    logic [11:0] c = 12'hB6D;
    c[p*3 +: 3] = m;
    return c;
  endfunction

  task automatic fill(input logic [15:0] base, input logic [15:0] step);
    for (int k = 0; k < 18; k++)
      sbuf[k] = base + 16'(((k * int'(step) + 13) % 53) * 11);
  endtask

  // Entered just after a falling edge; leaves just after a falling edge.
  task automatic run_set(input logic [1:0] p0, input logic [11:0] c0,
                         input logic [1:0] p1, input logic [11:0] c1,
                         input int n, input logic [15:0] expv, input string tag);
    for (int i = 0; i < n; i++) begin
      smp_valid = 1'b1;
      smp_data  = sbuf[i];
      pt_sel    = (i == 0) ? p0 : p1;
      ctrl_word = (i == 0) ? c0 : c1;
      @(negedge clk);
      if (i < n - 1) begin
        check({tag, " R9 early pulse"}, {31'd0, out_valid}, 32'd0);
      end else begin
        check({tag, " R9 done pulse"}, {31'd0, out_valid}, 32'd1);
        check({tag, " value"}, {16'd0, out_data}, {16'd0, expv});
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] last_val;
    rst_n = 1'b0;
    smp_valid = 1'b0;
    smp_data = '0;
    pt_sel = '0;
    ctrl_word = '0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 reset out_valid", {31'd0, out_valid}, 32'd0);
    check("R12 reset out_data", {16'd0, out_data}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk; sets run back to back (R10) with distinct points (R7).
    for (int v = 0; v < 10; v++) begin
      logic [1:0]  p = VTAB[v][36:35];
      logic [2:0]  m = VTAB[v][34:32];
      logic [11:0] c = ctrl_for(p, m);
      fill(VTAB[v][31:16], VTAB[v][15:0]);
      run_set(p, c, p, c, need_of(m), expect_of(m), {tag_of(m), " R7 R10"});
    end
    smp_valid = 1'b0;

    // R14: value holds while idle
    last_val = out_data;
    repeat (4) begin
      @(negedge clk);
      check("R14 hold", {16'd0, out_data}, {16'd0, last_val});
    end

    // R13: invalid cycles with changing data contribute nothing
    for (int k = 0; k < 5; k++) begin
      smp_data = 16'hFFFF - 16'(k * 4099);
      @(negedge clk);
      check("R13 idle no pulse", {31'd0, out_valid}, 32'd0);
    end
    sbuf[0] = 16'd100;
    sbuf[1] = 16'd203;
    run_set(2'd0, ctrl_for(2'd0, 3'd1), 2'd0, ctrl_for(2'd0, 3'd1), 2, 16'd151, "R13 R2");
    smp_valid = 1'b0;
    @(negedge clk);

    // R11: changes after the first sample are ignored
    fill(16'h3000, 16'd11);
    run_set(2'd2, ctrl_for(2'd2, 3'd2), 2'd0, 12'h000, 4, expect_of(3'd2), "R11");
    smp_valid = 1'b0;
    @(negedge clk);

    // R7: point 3 takes bits [11:9]
    fill(16'h0200, 16'd19);
    run_set(2'd3, 12'b001_000_000_000, 2'd3, 12'b001_000_000_000, 2, expect_of(3'd1), "R7");
    smp_valid = 1'b0;
    @(negedge clk);

    // R12: reset in mid-set discards the partial set
    fill(16'h4000, 16'd13);
    for (int i = 0; i < 2; i++) begin
      smp_valid = 1'b1;
      smp_data  = sbuf[i];
      pt_sel    = 2'd1;
      ctrl_word = ctrl_for(2'd1, 3'd2);
      @(negedge clk);
    end
    smp_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R12 mid-set reset out_valid", {31'd0, out_valid}, 32'd0);
    check("R12 mid-set reset out_data", {16'd0, out_data}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    sbuf[0] = 16'h0BEE;
    run_set(2'd1, ctrl_for(2'd1, 3'd0), 2'd1, ctrl_for(2'd1, 3'd0), 1, 16'h0BEE, "R12 R1");
    smp_valid = 1'b0;
    @(negedge clk);
    check("R9 single pulse", {31'd0, out_valid}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule